// File: doc/BRIEF.md
# Streaming Echo Transmission Checker

This block confirms that a remote host returned exactly the selection bytes held in a small local choice store. While the echo is still arriving, the checker drives a read address straight into the store over a dedicated side port. The store returns the reference byte combinationally, and each echoed byte is compared with it in the cycle it is presented. The echo is never buffered.

A confirmation pass begins with a one-cycle synchronous clear. After the last reference position has been compared, the block raises a done flag and a single transmission-good verdict. Both hold until the next clear or reset. Any bytes that arrive after the verdict is reached leave it unchanged.

Top module: `echo_tx_check`

## Requirements
- R1: After the asynchronous reset is released, and after a clear, `ref_addr_o` is 0, `done_o` is 0 and `tx_good_o` is 0.
- R2: Each accepted echo byte advances `ref_addr_o` by one, in the order 0, 1, ... DEPTH-1. An echo byte is accepted when `echo_valid_i` is 1, `done_o` is 0 and `clr_i` is 0. After the last position the address returns to 0.
- R3: An accepted byte is compared with the `ref_data_i` value presented in that same cycle, which is the store's content at the current `ref_addr_o`.
- R4: A mismatching byte sets an error condition that stays set until the next clear or reset. Later matching bytes do not remove it.
- R5: `done_o` rises in the cycle after the byte at address DEPTH-1 is accepted. From then on, `tx_good_o` is 1 exactly when no accepted byte of the pass mismatched.
- R6: Echo bytes that arrive while `done_o` is 1 are ignored. `done_o`, `tx_good_o` and `ref_addr_o` keep their values.
- R7: `tx_good_o` is 0 whenever `done_o` is 0, that is, while a check is in progress.
- R8: `clr_i` is synchronous and overrides a valid byte in the same cycle. In the next cycle `ref_addr_o` is 0, `done_o` is 0 and `tx_good_o` is 0.
- R9: A cycle with `echo_valid_i` low leaves `ref_addr_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_i | input | 1 | Synchronous clear that starts a new confirmation pass |
| echo_valid_i | input | 1 | Echo byte strobe |
| echo_data_i | input | DATA_W | Echoed byte |
| ref_addr_o | output | ADDR_W | Read address into the choice store |
| ref_data_i | input | DATA_W | Reference byte returned by the store for `ref_addr_o` |
| done_o | output | 1 | All DEPTH positions compared |
| tx_good_o | output | 1 | Verdict: done with no mismatch |

## Verification
The bench builds the block with its defaults: DATA_W of 8 and DEPTH of 4, which gives a 2-bit address. This depth lets short passes reach the last address and the wrap back to 0. It also covers mismatches at the first and at the final position, and stray bytes after the verdict. Each of these needs only a handful of cycles. The store contents are rewritten between passes, so a correct verdict depends on the address the block presents rather than on fixed data.

// File: rtl/echo_chk_pkg.sv
package echo_chk_pkg;

  // Phase of a confirmation pass.
  typedef enum logic {
    PH_RUN  = 1'b0,
    PH_DONE = 1'b1
  } chk_phase_e;

  // Registered verdict state.
  typedef struct packed {
    chk_phase_e phase;
    logic       bad;
  } verdict_t;

endpackage

// File: rtl/echo_rst_sync.sv
module echo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  // Asserts asynchronously, releases on the clock.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/echo_addr_seq.sv
module echo_addr_seq #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addr_q, addr_d;

  assign last_o = (addr_q == LAST_ADDR);

  always_comb begin
    addr_d = addr_q;
    if (clr_i)       addr_d = '0;
    else if (step_i) addr_d = last_o ? '0 : addr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)                addr_q <= '0;
    else if (clr_i || step_i)  addr_q <= addr_d;
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/echo_byte_cmp.sv
module echo_byte_cmp #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] lhs_i,
  input  logic [DATA_W-1:0] rhs_i,
  output logic              diff_o
);

  logic [DATA_W-1:0] bit_diff;

  // One XOR per bit, then an OR reduction.
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign bit_diff[b] = lhs_i[b] ^ rhs_i[b];
  end

  assign diff_o = |bit_diff;

endmodule

// File: rtl/echo_verdict.sv
module echo_verdict
  import echo_chk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_n,
  input  logic clr_i,
  input  logic step_i,
  input  logic last_i,
  input  logic diff_i,
  output logic done_o,
  output logic bad_o
);

  verdict_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (clr_i) begin
      st_d.phase = PH_RUN;
      st_d.bad   = 1'b0;
    end else if (step_i) begin
      if (diff_i) st_d.bad   = 1'b1;
      if (last_i) st_d.phase = PH_DONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      st_q.phase <= PH_RUN;
      st_q.bad   <= 1'b0;
    end else if (clr_i || step_i) begin
      st_q <= st_d;
    end
  end

  assign done_o = (st_q.phase == PH_DONE);
  assign bad_o  = st_q.bad;

endmodule

// File: rtl/echo_tx_check.sv
module echo_tx_check #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              clr_i,
  input  logic              echo_valid_i,
  input  logic [DATA_W-1:0] echo_data_i,
  output logic [ADDR_W-1:0] ref_addr_o,
  input  logic [DATA_W-1:0] ref_data_i,
  output logic              done_o,
  output logic              tx_good_o
);

  logic rst_n_sync;
  logic step;
  logic last_pos;
  logic diff;
  logic done;
  logic bad;

  echo_rst_sync #(.STAGES(2)) u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n_sync)
  );

  // A byte counts only while the pass is open and no clear is requested.
  assign step = echo_valid_i & ~done & ~clr_i;

  echo_addr_seq #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_seq (
    .clk_i  (clk_i),
    .rst_n  (rst_n_sync),
    .clr_i  (clr_i),
    .step_i (step),
    .addr_o (ref_addr_o),
    .last_o (last_pos)
  );

  echo_byte_cmp #(.DATA_W(DATA_W)) u_cmp (
    .lhs_i  (echo_data_i),
    .rhs_i  (ref_data_i),
    .diff_o (diff)
  );

  echo_verdict u_verdict (
    .clk_i  (clk_i),
    .rst_n  (rst_n_sync),
    .clr_i  (clr_i),
    .step_i (step),
    .last_i (last_pos),
    .diff_i (diff),
    .done_o (done),
    .bad_o  (bad)
  );

  assign done_o    = done;
  assign tx_good_o = done & ~bad;

endmodule

// File: rtl/echo_tx_check_sva.sv
module echo_tx_check_sva #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              clr_i,
  input logic              echo_valid_i,
  input logic [DATA_W-1:0] echo_data_i,
  input logic [ADDR_W-1:0] ref_addr_o,
  input logic [DATA_W-1:0] ref_data_i,
  input logic              done_o,
  input logic              tx_good_o
);

  logic              take;
  logic [ADDR_W-1:0] addr_after;

  assign take = echo_valid_i && !done_o && !clr_i;

  always_comb begin
    if (ref_addr_o == ADDR_W'(DEPTH - 1)) addr_after = '0;
    else                                  addr_after = ref_addr_o + 1'b1;
  end

  assert_addr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    take |=> ref_addr_o == $past(addr_after));

  assert_mismatch_kills_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (take && echo_data_i != ref_data_i) |=> !tx_good_o);

  assert_bad_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_o && !tx_good_o && !clr_i) |=> !tx_good_o);

  assert_done_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (take && ref_addr_o == ADDR_W'(DEPTH - 1)) |=> done_o);

  assert_late_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_o && !clr_i) |=> (done_o && $stable(tx_good_o) && $stable(ref_addr_o)));

  assert_busy_not_good_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !done_o |-> !tx_good_o);

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    clr_i |=> (!done_o && !tx_good_o && ref_addr_o == '0));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!echo_valid_i && !clr_i) |=> $stable(ref_addr_o));

endmodule

bind echo_tx_check echo_tx_check_sva #(
  .DATA_W (DATA_W),
  .DEPTH  (DEPTH),
  .ADDR_W (ADDR_W)
) u_sva (
  .clk_i        (clk_i),
  .rst_n        (rst_n_sync),
  .clr_i        (clr_i),
  .echo_valid_i (echo_valid_i),
  .echo_data_i  (echo_data_i),
  .ref_addr_o   (ref_addr_o),
  .ref_data_i   (ref_data_i),
  .done_o       (done_o),
  .tx_good_o    (tx_good_o)
);

// File: tb/echo_tx_check_tb.sv
`timescale 1ns/1ps
module echo_tx_check_tb;

  localparam int DW = 8;
  localparam int DP = 4;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clr;
  logic          vld;
  logic [DW-1:0] dat;
  logic [AW-1:0] addr;
  logic [DW-1:0] rdat;
  logic          done;
  logic          good;

  logic [DW-1:0] store [DP];

  int tests = 0;
  int fails = 0;
  bit live  = 1'b0;
  bit ended = 1'b0;

  // Reference model state
  logic [AW-1:0] m_addr;
  bit            m_done;
  bit            m_bad;
  logic [AW-1:0] exp_q [$];

  always #4 clk = ~clk;

  assign rdat = store[addr];

  echo_tx_check #(.DATA_W(DW), .DEPTH(DP), .ADDR_W(AW)) u_dut (
    .clk_i        (clk),
    .rst_n_i      (rst_n),
    .clr_i        (clr),
    .echo_valid_i (vld),
    .echo_data_i  (dat),
    .ref_addr_o   (addr),
    .ref_data_i   (rdat),
    .done_o       (done),
    .tx_good_o    (good)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus; pushes the expected address for the monitor.
  task automatic drive(input bit c, input bit v, input logic [DW-1:0] d);
    @(posedge clk);
    #1;
    clr = c;
    vld = v;
    dat = d;
    if (v) exp_q.push_back(m_addr);
    if (c) begin
      m_addr = '0;
      m_done = 1'b0;
      m_bad  = 1'b0;
    end else if (v && !m_done) begin
      if (d != store[m_addr]) m_bad = 1'b1;
      if (m_addr == AW'(DP - 1)) begin
        m_done = 1'b1;
        m_addr = '0;
      end else begin
        m_addr = m_addr + 1'b1;
      end
    end
  endtask

  // Monitor: address presented while a byte is on the bus (R2, R3 path).
  always @(negedge clk) begin
    if (live && vld && exp_q.size() > 0) begin
      automatic logic [AW-1:0] e = exp_q.pop_front();
      check(addr == e, "R2 address during echo byte", int'(addr), int'(e));
    end
  end

  task automatic idle_and_check(input string req);
    drive(1'b0, 1'b0, '0);
    #2;
    check(done == m_done, {req, " done"}, int'(done), int'(m_done));
    check(good == (m_done && !m_bad), {req, " tx_good"}, int'(good), int'(m_done && !m_bad));
    check(addr == m_addr, {req, " address"}, int'(addr), int'(m_addr));
  endtask

  task automatic run_pass(input logic [DW-1:0] e0, input logic [DW-1:0] e1,
                          input logic [DW-1:0] e2, input logic [DW-1:0] e3);
    drive(1'b1, 1'b0, '0);
    drive(1'b0, 1'b1, e0);
    drive(1'b0, 1'b1, e1);
    drive(1'b0, 1'b1, e2);
    drive(1'b0, 1'b1, e3);
  endtask

  initial begin
    #(8 * 200000);
    if (!ended) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    clr = 1'b0;
    vld = 1'b0;
    dat = '0;
    m_addr = '0;
    m_done = 1'b0;
    m_bad = 1'b0;
    store[0] = 8'h3C; store[1] = 8'hA5; store[2] = 8'h0F; store[3] = 8'hD2;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    live = 1'b1;

    // R1: state after reset
    idle_and_check("R1 after reset");

    // R5: matching pass, back to back
    run_pass(8'h3C, 8'hA5, 8'h0F, 8'hD2);
    idle_and_check("R5 good pass");
    check(good == 1'b1, "R5 verdict good", int'(good), 1);

    // R6: stray bytes after done, wrong values
    drive(1'b0, 1'b1, 8'h00);
    drive(1'b0, 1'b1, 8'hFF);
    idle_and_check("R6 after stray bytes");
    check(good == 1'b1, "R6 verdict kept", int'(good), 1);

    // R8: clear resets, R1 after clear
    drive(1'b1, 1'b0, '0);
    idle_and_check("R1 after clear");

    // R7 and R9: partial pass with gaps
    drive(1'b0, 1'b1, 8'h3C);
    drive(1'b0, 1'b0, 8'hA5);
    drive(1'b0, 1'b0, 8'h00);
    idle_and_check("R9 gap holds address");
    drive(1'b0, 1'b1, 8'hA5);
    idle_and_check("R7 in progress");
    check(good == 1'b0, "R7 not good mid-pass", int'(good), 0);
    drive(1'b0, 1'b1, 8'h0F);
    drive(1'b0, 1'b0, 8'h0F);
    drive(1'b0, 1'b1, 8'hD2);
    idle_and_check("R5 good pass with gaps");

    // R4: mismatch at first byte, rest match
    run_pass(8'h3D, 8'hA5, 8'h0F, 8'hD2);
    idle_and_check("R4 first byte bad");
    check(good == 1'b0, "R4 sticky error", int'(good), 0);

    // Boundary: mismatch only on the final position
    run_pass(8'h3C, 8'hA5, 8'h0F, 8'hD3);
    idle_and_check("R4 last byte bad");

    // R3: new store contents, echo of old contents must fail
    store[0] = 8'h11; store[1] = 8'h22; store[2] = 8'h33; store[3] = 8'h44;
    run_pass(8'h3C, 8'hA5, 8'h0F, 8'hD2);
    idle_and_check("R3 stale echo");
    run_pass(8'h11, 8'h22, 8'h33, 8'h44);
    idle_and_check("R3 fresh echo");
    check(good == 1'b1, "R3 verdict good", int'(good), 1);

    // R8: clear with a valid byte in the same cycle, mid-pass
    drive(1'b1, 1'b0, '0);
    drive(1'b0, 1'b1, 8'h11);
    drive(1'b0, 1'b1, 8'h99);
    drive(1'b1, 1'b1, 8'h33);
    idle_and_check("R8 clear beats byte");
    run_pass(8'h11, 8'h22, 8'h33, 8'h44);
    idle_and_check("R8 pass after clear");

    ended = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule